// File: doc/BRIEF.md
# Dual-channel high/low-time PWM generator

This block produces two pulse-width-modulated outputs, each meant to drive one DAC input through an external filter. Software programs each channel with two independent lengths, counted in clock ticks: how long the output stays high and how long it then stays low. While a channel is enabled, it repeats that high-then-low pattern without end. A shared control word switches each channel on and off. The same word also holds an enable flag for a neighbouring CAN controller, which this block only stores and drives out on a pin.

Software reaches the block through a small synchronous register port. The port has a select strobe, a write strobe, a halfword address and 16-bit data. Every register is 16 bits wide, and register n sits at byte offset 2n. A read request returns its data on `bus_rdata` one clock later. A channel takes new lengths only at the end of a phase, so a phase that is already running always completes at its old length.

Top module: `dual_phase_pwm`

## Requirements
- R1: After reset, every register reads 0, both `pwm_out` bits are 0, `can_en` is 0 and `bus_rdata` is 0.
- R2: The halfword address selects the register: 0 is control, 1 is the channel 0 high length, 2 is the channel 0 low length, 3 is the channel 1 high length and 4 is the channel 1 low length. A write takes effect at the clock edge on which `bus_sel` and `bus_wr` are both high. A read request (`bus_sel` high, `bus_wr` low) places the data on `bus_rdata` after that edge, and a read of any other address returns 0.
- R3: In the control register, bit 0 enables channel 0, bit 1 enables channel 1 and bit 2 drives `can_en`. Bits 15:3 ignore writes and always read as 0.
- R4: A channel whose enable bit has just been set starts its high phase on the next clock edge. Its output is then high for H cycles and low for L cycles, and it repeats, where H and L are its programmed lengths.
- R5: A channel's output is low in every cycle in which its enable bit reads 0, including the cycle just after the write that clears the bit. A later enable starts again with a full high phase.
- R6: A new length written while a channel runs does not change the phase in progress. Both new lengths are taken at the next phase boundary.
- R7: With a high length of 0, an enabled channel's output stays low.
- R8: With a low length of 0 and a nonzero high length, an enabled channel's output stays high.
- R9: The two channels run independently: the settings and the enable of one never change the other's output.
- R10: A write to an address above 4 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read, qualified by `bus_sel` |
| bus_addr | input | 3 | Halfword register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid on the cycle after a read request |
| pwm_out | output | 2 | PWM output, one bit per channel |
| can_en | output | 1 | Stored CAN enable flag |

## Verification
The bench builds the block with its default parameters: 16-bit data and two channels, which gives a 3-bit address and places the CAN flag at control bit 2. With 16-bit lengths, the bench can program lengths of 0, 1 and other small values. This brings the zero-length cases, one-tick phases and a rewrite just before a phase boundary within a few dozen cycles. Address values 5 to 7 lie past the last register, so the unmapped write and read paths can be reached with the same 3-bit port.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    // Phase of one PWM channel
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           bus_sel,
    input  logic                           bus_wr,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic [DATA_W-1:0]              bus_wdata,
    output logic [DATA_W-1:0]              bus_rdata,
    output logic [NUM_CH-1:0]              ch_en,
    output logic                           can_flag,
    output logic [NUM_CH-1:0][DATA_W-1:0]  hi_len,
    output logic [NUM_CH-1:0][DATA_W-1:0]  lo_len
);

    // Control word: one enable per channel, then the CAN flag
    localparam int CTRL_W  = NUM_CH + 1;
    localparam int LAST_RG = 2 * NUM_CH;

    typedef struct packed {
        logic [CTRL_W-1:0]             ctrl;
        logic [NUM_CH-1:0][DATA_W-1:0] hi;
        logic [NUM_CH-1:0][DATA_W-1:0] lo;
        logic [DATA_W-1:0]             rdata;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (bus_sel && bus_wr) begin
            if (bus_addr == '0) begin
                d.ctrl = bus_wdata[CTRL_W-1:0];
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == ADDR_W'(2 * c + 1)) d.hi[c] = bus_wdata;
                if (bus_addr == ADDR_W'(2 * c + 2)) d.lo[c] = bus_wdata;
            end
        end
        if (bus_sel && !bus_wr) begin
            d.rdata = '0;
            if (bus_addr == '0) begin
                d.rdata[CTRL_W-1:0] = q.ctrl;
            end
            for (int c = 0; c < NUM_CH; c++) begin
                if (bus_addr == ADDR_W'(2 * c + 1)) d.rdata = q.hi[c];
                if (bus_addr == ADDR_W'(2 * c + 2)) d.rdata = q.lo[c];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bus_rdata = q.rdata;
    assign ch_en     = q.ctrl[NUM_CH-1:0];
    assign can_flag  = q.ctrl[NUM_CH];
    assign hi_len    = q.hi;
    assign lo_len    = q.lo;

    // R3: a control write stores exactly the defined bits
    a_r3_ctrl_store: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == '0)
        |=> ({can_flag, ch_en} == $past(bus_wdata[CTRL_W-1:0])));

    // R3: reserved control bits read as zero
    a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == '0)
        |=> (bus_rdata[DATA_W-1:CTRL_W] == '0));

    // R10: writes past the last register leave all registers untouched
    a_r10_unmapped_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr > ADDR_W'(LAST_RG))
        |=> ($stable(ch_en) && $stable(can_flag) && $stable(hi_len) && $stable(lo_len)));

    // R2: reads outside the map return zero
    a_r2_unmapped_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr > ADDR_W'(LAST_RG))
        |=> (bus_rdata == '0));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [DATA_W-1:0] hi_i,
    input  logic [DATA_W-1:0] lo_i,
    output logic              pwm_o
);

    import pwm_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic [DATA_W-1:0] cnt;
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } chan_t;

    chan_t q, d;

    always_comb begin
        d = q;
        unique case (q.phase)
            PH_IDLE: begin
                d.cnt = '0;
                if (en_i) begin
                    d.hi    = hi_i;
                    d.lo    = lo_i;
                    d.cnt   = DATA_W'(1);
                    d.phase = (hi_i != '0) ? PH_HIGH : PH_LOW;
                end
            end
            PH_HIGH: begin
                if (!en_i) begin
                    d.phase = PH_IDLE;
                    d.cnt   = '0;
                end else if (q.cnt >= q.hi) begin
                    d.hi  = hi_i;
                    d.lo  = lo_i;
                    d.cnt = DATA_W'(1);
                    if (lo_i != '0)      d.phase = PH_LOW;
                    else if (hi_i != '0) d.phase = PH_HIGH;
                    else                 d.phase = PH_LOW;
                end else begin
                    d.cnt = q.cnt + DATA_W'(1);
                end
            end
            PH_LOW: begin
                if (!en_i) begin
                    d.phase = PH_IDLE;
                    d.cnt   = '0;
                end else if (q.cnt >= q.lo) begin
                    d.hi    = hi_i;
                    d.lo    = lo_i;
                    d.cnt   = DATA_W'(1);
                    d.phase = (hi_i != '0) ? PH_HIGH : PH_LOW;
                end else begin
                    d.cnt = q.cnt + DATA_W'(1);
                end
            end
            default: begin
                d.phase = PH_IDLE;
                d.cnt   = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pwm_o = en_i && (q.phase == PH_HIGH);

    // R5: a cleared enable returns the channel to its idle phase
    a_r5_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (q.phase == PH_IDLE));

    // R4: the high-phase counter stays within the latched length
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_HIGH) |-> (q.cnt >= DATA_W'(1) && q.cnt <= q.hi));

    // R7: a zero high length never produces a high phase
    a_r7_no_zero_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_HIGH) |-> (q.hi != '0));

    // R6: latched lengths change only at a phase boundary
    a_r6_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.phase != PH_IDLE) && (q.cnt != DATA_W'(1))) |-> ($stable(q.hi) && $stable(q.lo)));

endmodule

// File: rtl/dual_phase_pwm.sv
module dual_phase_pwm #(
    parameter int DATA_W = 16,
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NUM_CH-1:0] pwm_out,
    output logic              can_en
);

    logic [NUM_CH-1:0]             ch_en;
    logic [NUM_CH-1:0][DATA_W-1:0] hi_len;
    logic [NUM_CH-1:0][DATA_W-1:0] lo_len;

    pwm_regs #(
        .DATA_W (DATA_W),
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ch_en     (ch_en),
        .can_flag  (can_en),
        .hi_len    (hi_len),
        .lo_len    (lo_len)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        pwm_chan #(
            .DATA_W (DATA_W)
        ) i_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (ch_en[c]),
            .hi_i  (hi_len[c]),
            .lo_i  (lo_len[c]),
            .pwm_o (pwm_out[c])
        );
    end

    // R5: a disabled channel never drives high
    a_r5_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwm_out & ~ch_en) == '0));

endmodule

// File: tb/test_dual_phase_pwm.sv
module test_dual_phase_pwm;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [1:0]  pwm_out;
    logic        can_en;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_ctrl;
    int m_hi[2];
    int m_lo[2];
    int m_rd;
    int m_mode[2];   // 0 idle, 1 high, 2 low
    int m_left[2];   // cycles remaining in current phase

    always #(CLK_PERIOD / 2) clk = ~clk;

    dual_phase_pwm i_dual_phase_pwm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out),
        .can_en    (can_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int reg_value(input int a);
        case (a)
            0: return m_ctrl;
            1: return m_hi[0];
            2: return m_lo[0];
            3: return m_hi[1];
            4: return m_lo[1];
            default: return 0;
        endcase
    endfunction

    function automatic void start_phase(input int c, input bit from_high);
        int h = m_hi[c];
        int l = m_lo[c];
        if (from_high && l > 0) begin
            m_mode[c] = 2; m_left[c] = l;
        end else if (h > 0) begin
            m_mode[c] = 1; m_left[c] = h;
        end else begin
            m_mode[c] = 2; m_left[c] = (l > 0) ? l : 1;
        end
    endfunction

    // behavioural model, advanced on each rising edge with pre-edge values
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ctrl = 0; m_rd = 0;
            for (int c = 0; c < 2; c++) begin
                m_hi[c] = 0; m_lo[c] = 0; m_mode[c] = 0; m_left[c] = 0;
            end
        end else begin
            for (int c = 0; c < 2; c++) begin
                if (((m_ctrl >> c) & 1) == 0) begin
                    m_mode[c] = 0;
                end else if (m_mode[c] == 0) begin
                    start_phase(c, 1'b0);
                end else if (m_left[c] <= 1) begin
                    start_phase(c, m_mode[c] == 1);
                end else begin
                    m_left[c]--;
                end
            end
            if (bus_sel && !bus_wr) m_rd = reg_value(int'(bus_addr));
            if (bus_sel && bus_wr) begin
                case (int'(bus_addr))
                    0: m_ctrl = int'(bus_wdata) & 7;
                    1: m_hi[0] = int'(bus_wdata);
                    2: m_lo[0] = int'(bus_wdata);
                    3: m_hi[1] = int'(bus_wdata);
                    4: m_lo[1] = int'(bus_wdata);
                    default: ;
                endcase
            end
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            for (int c = 0; c < 2; c++)
                chk(cur_req, int'(pwm_out[c]),
                    (((m_ctrl >> c) & 1) == 1 && m_mode[c] == 1) ? 1 : 0);
            chk({cur_req, "/R3 can_en"}, int'(can_en), (m_ctrl >> 2) & 1);
            chk({cur_req, "/R2 rdata"}, int'(bus_rdata), m_rd);
        end
    end

    task automatic wr(input int a, input int v);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 16'(v);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, input int exp, input string req);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 3'(a);
        @(negedge clk);
        bus_sel = 1'b0;
        chk(req, int'(bus_rdata), exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        // R1: reset state
        chk("R1 pwm", int'(pwm_out), 0);
        chk("R1 can_en", int'(can_en), 0);
        chk("R1 rdata", int'(bus_rdata), 0);
        rst_n = 1'b1;
        idle(1);
        cmp_on = 1'b1;
        for (int a = 0; a < 5; a++) rd(a, 0, "R1 register reset");

        // R2: map and readback
        cur_req = "R2";
        wr(1, 3); wr(2, 5); wr(3, 4); wr(4, 2);
        rd(1, 3, "R2 ch0 high");
        rd(2, 5, "R2 ch0 low");
        rd(3, 4, "R2 ch1 high");
        rd(4, 2, "R2 ch1 low");
        rd(6, 0, "R2 unmapped read");

        // R3: reserved bits and CAN flag
        cur_req = "R3";
        wr(0, 16'hFFF8);
        rd(0, 0, "R3 reserved ignored");
        chk("R3 can off", int'(can_en), 0);
        wr(0, 16'hFFFF);
        chk("R3 can on", int'(can_en), 1);
        // R4 / R5: enable starts high on the next edge
        chk("R4 not yet high", int'(pwm_out), 0);
        idle(1);
        chk("R4 first high", int'(pwm_out), 3);
        cur_req = "R4/R9";
        idle(1);
        rd(0, 7, "R3 control readback");
        idle(40);

        // R6: rewrite mid-phase
        cur_req = "R6";
        wr(1, 7); wr(2, 1);
        idle(30);
        wr(3, 1); wr(4, 1);
        idle(20);

        // R5: disable then re-enable channel 0
        cur_req = "R5";
        wr(0, 6);
        chk("R5 low after disable", int'(pwm_out[0]), 0);
        idle(7);
        wr(0, 7);
        idle(1);
        chk("R5 restart high", int'(pwm_out[0]), 1);
        idle(20);

        // R7: zero high length on channel 1
        cur_req = "R7";
        wr(3, 0);
        idle(10);
        for (int i = 0; i < 10; i++) begin
            chk("R7 const low", int'(pwm_out[1]), 0);
            idle(1);
        end

        // R8: zero low length on channel 0
        cur_req = "R8";
        wr(1, 2); wr(2, 0);
        idle(20);
        for (int i = 0; i < 10; i++) begin
            chk("R8 const high", int'(pwm_out[0]), 1);
            idle(1);
        end

        // R9: channel 1 lengths restored, channel 0 unaffected
        cur_req = "R9";
        wr(3, 2); wr(4, 3);
        idle(25);

        // R10: writes past the map
        cur_req = "R10";
        wr(5, 16'h1234); wr(6, 16'h5678); wr(7, 16'h0000);
        rd(0, 7, "R10 control kept");
        rd(1, 2, "R10 ch0 high kept");
        rd(2, 0, "R10 ch0 low kept");
        rd(3, 2, "R10 ch1 high kept");
        rd(4, 3, "R10 ch1 low kept");
        idle(10);

        cur_req = "R3";
        wr(0, 0);
        chk("R3 all off", int'({can_en, pwm_out}), 0);
        idle(5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule